// File: doc/BRIEF.md
# Paging Unit Control and Status Register Block

This block is the software-facing control port of a paging address translation unit. A simple 32-bit register bus with byte offsets gives access to the page directory base, a command register, a status word, the captured fault address, a one-page invalidate port, and a set of interrupt registers (raw, clear, mask, masked). The page walker and bus master stay outside. They report in-flight translations, page faults and bus errors on input pins, and they receive the paging and stall modes, the directory base and the cache invalidate pulses on output pins.

Commands written to the command register step three independent mode channels: paging on/off, stall on/off, and force reset. Each channel takes effect a fixed number of cycles after its command. Software polls the status word, or the directory base for the reset, to see when a change has landed. A page fault is held, with its address and direction, until software acknowledges it. Fault and bus-error events set sticky interrupt bits, and the interrupt line is raised while any unmasked bit is set.

Top module: `xlat_ctl_top`

## Requirements
- R1: After reset the directory base reads 0, the mask reads 0, the interrupt line is low, and paging and stall are off. The status word at offset 0x04 then reads 0x8000_0018 when no walk is in flight and the replay buffer reports empty.
- R2: The directory base register at offset 0x00 stores only bits 31:12 and reads the low 12 bits as zero. Writing 0xCAFEBABE reads back 0xCAFEB000.
- R3: Writing 0 (enable) or 1 (disable) to the command register at offset 0x08 changes paging, shown in status bit 0, exactly CMD_DELAY cycles after the write cycle. Command values 7 and above change nothing.
- R4: Command 6 (force reset) clears the directory base to zero, turns paging off and releases any held fault, all CMD_DELAY cycles after the write. The directory base keeps its old value until then.
- R5: Command 2 (stall on) is dropped while paging is off. While paging is on, its countdown advances only in cycles with no translation in flight. Once granted, status bit 2 reads 1 and bit 31 reads 0. Command 3 (stall off) clears bit 2 after CMD_DELAY cycles.
- R6: Command 4 gives a one-cycle whole-cache flush pulse in the cycle after the write.
- R7: A write to offset 0x10 gives a one-cycle line-invalidate pulse in the cycle after the write, carrying bits 31:12 of the written address as the page number.
- R8: A fault report accepted while no fault is held sets status bit 1 and raw interrupt bit 0. It latches the address, readable at offset 0x0C, and the write direction, shown in status bit 5. Reports arriving while a fault is held change nothing.
- R9: Command 5 (fault handled) releases the held fault in the cycle after the write, so the next fault report is captured.
- R10: A bus-error report sets raw interrupt bit 1 (raw register at offset 0x14). Writing ones to offset 0x18 clears the matching raw bits. A source event in the same cycle as its clear leaves the bit set.
- R11: The mask register at offset 0x1C holds two bits. Offset 0x20 reads raw AND mask, and the interrupt line is the OR of those masked bits.
- R12: Offset 0x24 is a one-bit read/write register (bit 0) that drives the clock-gating enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| walk_busy_i | input | 1 | A translation is in flight |
| replay_empty_i | input | 1 | Replay buffer is empty |
| fault_req_i | input | 1 | Page fault report, one cycle |
| fault_addr_i | input | 32 | Faulting address |
| fault_write_i | input | 1 | Faulting access was a write |
| bus_err_i | input | 1 | Bus error report, one cycle |
| paging_on_o | output | 1 | Paging mode |
| stall_on_o | output | 1 | Stall mode |
| dir_base_o | output | 32 | Page directory base |
| flush_all_o | output | 1 | Whole-cache flush pulse |
| line_inv_o | output | 1 | One-page invalidate pulse |
| line_page_o | output | 20 | Page number to invalidate |
| clk_gate_en_o | output | 1 | Clock-gating enable |
| irq_o | output | 1 | Interrupt line |

## Verification
A software clear of the raw interrupt register can fall in the same cycle as a new fault or bus-error report for the same bit. The bench drives the bus-error pin high at the same clock edge that takes a clear write covering both raw bits. It then reads the raw register and expects only the bus-error bit left set. A second collision places the force-reset completion edge against a pending fault. It is judged by reading the directory base and status word one cycle before and one cycle after the countdown ends.

// File: rtl/xlat_ctl_pkg.sv
package xlat_ctl_pkg;

   // register byte offsets
   localparam int unsigned OFS_DIR   = 'h00;
   localparam int unsigned OFS_STAT  = 'h04;
   localparam int unsigned OFS_CMD   = 'h08;
   localparam int unsigned OFS_FADDR = 'h0C;
   localparam int unsigned OFS_LINE  = 'h10;
   localparam int unsigned OFS_RAW   = 'h14;
   localparam int unsigned OFS_ICLR  = 'h18;
   localparam int unsigned OFS_MASK  = 'h1C;
   localparam int unsigned OFS_MSTAT = 'h20;
   localparam int unsigned OFS_GATE  = 'h24;

   typedef enum logic [2:0] {
      CMD_PG_ON   = 3'd0,
      CMD_PG_OFF  = 3'd1,
      CMD_STL_ON  = 3'd2,
      CMD_STL_OFF = 3'd3,
      CMD_FLUSH   = 3'd4,
      CMD_FLT_ACK = 3'd5,
      CMD_RESET   = 3'd6
   } xcmd_e;

   // mode channels
   localparam int unsigned CH_PAGE  = 0;
   localparam int unsigned CH_STALL = 1;
   localparam int unsigned CH_RST   = 2;
   localparam int unsigned NUM_CH   = 3;

   // status bit positions
   localparam int unsigned ST_PAGING = 0;
   localparam int unsigned ST_FAULT  = 1;
   localparam int unsigned ST_STALL  = 2;
   localparam int unsigned ST_IDLE   = 3;
   localparam int unsigned ST_REPLAY = 4;
   localparam int unsigned ST_FWRITE = 5;
   localparam int unsigned ST_NSTALL = 31;

   // interrupt source positions
   localparam int unsigned IRQ_FAULT  = 0;
   localparam int unsigned IRQ_BUSERR = 1;

endpackage

// File: rtl/xlat_delay_chan.sv
module xlat_delay_chan #(
   parameter int unsigned DELAY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic target_i,
   input  logic gate_i,
   output logic fire_o,
   output logic target_o
);
   localparam int unsigned CW = $clog2(DELAY + 1);

   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("xlat_delay_chan: DELAY must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          pend_q;
   logic          tgt_q;

   assign fire_o   = pend_q && gate_i && (cnt_q == CW'(1));
   assign target_o = tgt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
         tgt_q  <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= CW'(DELAY);
         pend_q <= 1'b1;
         tgt_q  <= target_i;
      end else if (pend_q && gate_i) begin
         if (fire_o) begin
            pend_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - CW'(1);
         end
      end
   end

   // R5
   hold_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !gate_i && !start_i) |=> ($stable(cnt_q) && pend_q));

endmodule

// File: rtl/xlat_irq_unit.sv
module xlat_irq_unit #(
   parameter int unsigned NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic               clr_we_i,
   input  logic [NUM_SRC-1:0] clr_bits_i,
   input  logic               mask_we_i,
   input  logic [NUM_SRC-1:0] mask_wdata_i,
   output logic [NUM_SRC-1:0] raw_o,
   output logic [NUM_SRC-1:0] mask_o,
   output logic [NUM_SRC-1:0] stat_o,
   output logic               irq_o
);
   generate
      if (NUM_SRC < 1) begin : g_bad_src
         $error("xlat_irq_unit: NUM_SRC must be at least 1");
      end
   endgenerate

   logic [NUM_SRC-1:0] raw_q;
   logic [NUM_SRC-1:0] mask_q;

   genvar k;
   generate
      for (k = 0; k < NUM_SRC; k++) begin : g_src
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               raw_q[k] <= 1'b0;
            end else if (set_i[k]) begin
               raw_q[k] <= 1'b1;
            end else if (clr_we_i && clr_bits_i[k]) begin
               raw_q[k] <= 1'b0;
            end
         end

         // R10
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> raw_o[k]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (mask_we_i) begin
         mask_q <= mask_wdata_i;
      end
   end

   assign raw_o  = raw_q;
   assign mask_o = mask_q;
   assign stat_o = raw_q & mask_q;
   assign irq_o  = |stat_o;

endmodule

// File: rtl/xlat_fault_trap.sv
module xlat_fault_trap #(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic [AW-1:0] addr_i,
   input  logic          write_i,
   input  logic          ack_i,
   input  logic          wipe_i,
   output logic          active_o,
   output logic [AW-1:0] addr_o,
   output logic          write_o,
   output logic          hit_o
);
   logic          active_q;
   logic [AW-1:0] addr_q;
   logic          wr_q;

   assign hit_o = req_i && !active_q && !wipe_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         addr_q   <= '0;
         wr_q     <= 1'b0;
      end else begin
         if (wipe_i) begin
            active_q <= 1'b0;
         end else if (hit_o) begin
            active_q <= 1'b1;
         end else if (ack_i) begin
            active_q <= 1'b0;
         end
         if (hit_o) begin
            addr_q <= addr_i;
            wr_q   <= write_i;
         end
      end
   end

   assign active_o = active_q;
   assign addr_o   = addr_q;
   assign write_o  = wr_q;

   // R8
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |=> ($stable(addr_o) && $stable(write_o)));

endmodule

// File: rtl/xlat_ctl_top.sv
module xlat_ctl_top
   import xlat_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned CMD_DELAY  = 3,
   parameter int unsigned NUM_SRC    = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            reg_addr,
   input  logic                         reg_wr,
   input  logic [DATA_W-1:0]            reg_wdata,
   output logic [DATA_W-1:0]            reg_rdata,
   input  logic                         walk_busy_i,
   input  logic                         replay_empty_i,
   input  logic                         fault_req_i,
   input  logic [DATA_W-1:0]            fault_addr_i,
   input  logic                         fault_write_i,
   input  logic                         bus_err_i,
   output logic                         paging_on_o,
   output logic                         stall_on_o,
   output logic [DATA_W-1:0]            dir_base_o,
   output logic                         flush_all_o,
   output logic                         line_inv_o,
   output logic [DATA_W-PAGE_SHIFT-1:0] line_page_o,
   output logic                         clk_gate_en_o,
   output logic                         irq_o
);
   localparam int unsigned PN_W = DATA_W - PAGE_SHIFT;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("xlat_ctl_top: DATA_W must be 32");
      end
      if (PAGE_SHIFT < 1 || PAGE_SHIFT >= DATA_W) begin : g_bad_page
         $error("xlat_ctl_top: PAGE_SHIFT out of range");
      end
      if (NUM_SRC < 2) begin : g_bad_src
         $error("xlat_ctl_top: NUM_SRC must cover fault and bus error");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("xlat_ctl_top: ADDR_W too small for the register map");
      end
   endgenerate

   // ---------------- write decode ----------------
   logic  we_dir, we_cmd, we_line, we_iclr, we_mask, we_gate;
   xcmd_e cmd_code;
   logic  cmd_ok;

   assign we_dir  = reg_wr && (reg_addr == ADDR_W'(OFS_DIR));
   assign we_cmd  = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
   assign we_line = reg_wr && (reg_addr == ADDR_W'(OFS_LINE));
   assign we_iclr = reg_wr && (reg_addr == ADDR_W'(OFS_ICLR));
   assign we_mask = reg_wr && (reg_addr == ADDR_W'(OFS_MASK));
   assign we_gate = reg_wr && (reg_addr == ADDR_W'(OFS_GATE));

   assign cmd_code = xcmd_e'(reg_wdata[2:0]);
   assign cmd_ok   = we_cmd && (reg_wdata[DATA_W-1:3] == '0) && (reg_wdata[2:0] != 3'd7);

   // ---------------- state ----------------
   logic              paging_q;
   logic              stall_q;
   logic [PN_W-1:0]   dir_q;
   logic              flush_q;
   logic              line_q;
   logic [PN_W-1:0]   page_q;
   logic              gate_q;

   // ---------------- mode channels ----------------
   logic [NUM_CH-1:0] ch_start;
   logic [NUM_CH-1:0] ch_tgt_in;
   logic [NUM_CH-1:0] ch_gate;
   logic [NUM_CH-1:0] ch_fire;
   logic [NUM_CH-1:0] ch_tgt;

   always_comb begin
      ch_start  = '0;
      ch_tgt_in = '0;
      ch_gate   = '1;
      ch_start[CH_PAGE]   = cmd_ok && (cmd_code == CMD_PG_ON || cmd_code == CMD_PG_OFF);
      ch_tgt_in[CH_PAGE]  = (cmd_code == CMD_PG_ON);
      ch_start[CH_STALL]  = cmd_ok && ((cmd_code == CMD_STL_ON && paging_q) ||
                                       cmd_code == CMD_STL_OFF);
      ch_tgt_in[CH_STALL] = (cmd_code == CMD_STL_ON);
      ch_gate[CH_STALL]   = !ch_tgt[CH_STALL] || (!walk_busy_i && paging_q);
      ch_start[CH_RST]    = cmd_ok && (cmd_code == CMD_RESET);
      ch_tgt_in[CH_RST]   = 1'b1;
   end

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_chan
         xlat_delay_chan #(
            .DELAY (CMD_DELAY)
         ) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (ch_start[c]),
            .target_i (ch_tgt_in[c]),
            .gate_i   (ch_gate[c]),
            .fire_o   (ch_fire[c]),
            .target_o (ch_tgt[c])
         );
      end
   endgenerate

   // ---------------- fault capture ----------------
   logic              flt_active;
   logic [DATA_W-1:0] flt_addr;
   logic              flt_write;
   logic              flt_hit;

   xlat_fault_trap #(
      .AW (DATA_W)
   ) i_trap (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (fault_req_i),
      .addr_i   (fault_addr_i),
      .write_i  (fault_write_i),
      .ack_i    (cmd_ok && (cmd_code == CMD_FLT_ACK)),
      .wipe_i   (ch_fire[CH_RST]),
      .active_o (flt_active),
      .addr_o   (flt_addr),
      .write_o  (flt_write),
      .hit_o    (flt_hit)
   );

   // ---------------- interrupts ----------------
   logic [NUM_SRC-1:0] irq_set;
   logic [NUM_SRC-1:0] irq_raw;
   logic [NUM_SRC-1:0] irq_mask;
   logic [NUM_SRC-1:0] irq_stat;

   always_comb begin
      irq_set             = '0;
      irq_set[IRQ_FAULT]  = flt_hit;
      irq_set[IRQ_BUSERR] = bus_err_i;
   end

   xlat_irq_unit #(
      .NUM_SRC (NUM_SRC)
   ) i_irq (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_i        (irq_set),
      .clr_we_i     (we_iclr),
      .clr_bits_i   (reg_wdata[NUM_SRC-1:0]),
      .mask_we_i    (we_mask),
      .mask_wdata_i (reg_wdata[NUM_SRC-1:0]),
      .raw_o        (irq_raw),
      .mask_o       (irq_mask),
      .stat_o       (irq_stat),
      .irq_o        (irq_o)
   );

   // ---------------- mode and register state ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         paging_q <= 1'b0;
         stall_q  <= 1'b0;
         dir_q    <= '0;
         flush_q  <= 1'b0;
         line_q   <= 1'b0;
         page_q   <= '0;
         gate_q   <= 1'b0;
      end else begin
         if (ch_fire[CH_RST]) begin
            paging_q <= 1'b0;
         end else if (ch_fire[CH_PAGE]) begin
            paging_q <= ch_tgt[CH_PAGE];
         end

         if (ch_fire[CH_STALL]) begin
            stall_q <= ch_tgt[CH_STALL];
         end

         if (ch_fire[CH_RST]) begin
            dir_q <= '0;
         end else if (we_dir) begin
            dir_q <= reg_wdata[DATA_W-1:PAGE_SHIFT];
         end

         flush_q <= cmd_ok && (cmd_code == CMD_FLUSH);
         line_q  <= we_line;
         if (we_line) begin
            page_q <= reg_wdata[DATA_W-1:PAGE_SHIFT];
         end

         if (we_gate) begin
            gate_q <= reg_wdata[0];
         end
      end
   end

   // ---------------- read mux ----------------
   logic [DATA_W-1:0] status_w;

   always_comb begin
      status_w             = '0;
      status_w[ST_PAGING]  = paging_q;
      status_w[ST_FAULT]   = flt_active;
      status_w[ST_STALL]   = stall_q;
      status_w[ST_IDLE]    = !walk_busy_i;
      status_w[ST_REPLAY]  = replay_empty_i;
      status_w[ST_FWRITE]  = flt_write;
      status_w[ST_NSTALL]  = !stall_q;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFS_DIR):   reg_rdata = {dir_q, {PAGE_SHIFT{1'b0}}};
         ADDR_W'(OFS_STAT):  reg_rdata = status_w;
         ADDR_W'(OFS_FADDR): reg_rdata = flt_addr;
         ADDR_W'(OFS_RAW):   reg_rdata = DATA_W'(irq_raw);
         ADDR_W'(OFS_MASK):  reg_rdata = DATA_W'(irq_mask);
         ADDR_W'(OFS_MSTAT): reg_rdata = DATA_W'(irq_stat);
         ADDR_W'(OFS_GATE):  reg_rdata = DATA_W'(gate_q);
         default:            reg_rdata = '0;
      endcase
   end

   // ---------------- outputs ----------------
   assign paging_on_o   = paging_q;
   assign stall_on_o    = stall_q;
   assign dir_base_o    = {dir_q, {PAGE_SHIFT{1'b0}}};
   assign flush_all_o   = flush_q;
   assign line_inv_o    = line_q;
   assign line_page_o   = page_q;
   assign clk_gate_en_o = gate_q;

   // R5
   stall_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_q) |-> ($past(!walk_busy_i) && $past(paging_q)));

   // R4
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_fire[CH_RST] |=> ((dir_base_o == '0) && !paging_on_o && !flt_active));

   // R6
   flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_all_o && !(cmd_ok && cmd_code == CMD_FLUSH)) |=> !flush_all_o);

endmodule

// File: tb/test_xlat_ctl_top.sv
module test_xlat_ctl_top;
   localparam int unsigned D = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        walk_busy_i = 1'b0;
   logic        replay_empty_i = 1'b1;
   logic        fault_req_i = 1'b0;
   logic [31:0] fault_addr_i = '0;
   logic        fault_write_i = 1'b0;
   logic        bus_err_i = 1'b0;
   logic        paging_on_o, stall_on_o, flush_all_o, line_inv_o, clk_gate_en_o, irq_o;
   logic [31:0] dir_base_o;
   logic [19:0] line_page_o;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   xlat_ctl_top i_xlat_ctl_top (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .walk_busy_i(walk_busy_i),
      .replay_empty_i(replay_empty_i), .fault_req_i(fault_req_i),
      .fault_addr_i(fault_addr_i), .fault_write_i(fault_write_i),
      .bus_err_i(bus_err_i), .paging_on_o(paging_on_o), .stall_on_o(stall_on_o),
      .dir_base_o(dir_base_o), .flush_all_o(flush_all_o), .line_inv_o(line_inv_o),
      .line_page_o(line_page_o), .clk_gate_en_o(clk_gate_en_o), .irq_o(irq_o)
   );

   // address, write data, expected read-back
   localparam logic [71:0] VEC [0:8] = '{
      {8'h00, 32'hCAFEBABE, 32'hCAFEB000},
      {8'h00, 32'hFFFFFFFF, 32'hFFFFF000},
      {8'h00, 32'h00000FFF, 32'h00000000},
      {8'h1C, 32'hFFFFFFFF, 32'h00000003},
      {8'h1C, 32'h00000002, 32'h00000002},
      {8'h1C, 32'h00000000, 32'h00000000},
      {8'h24, 32'h00000001, 32'h00000001},
      {8'h24, 32'hFFFFFFFE, 32'h00000000},
      {8'h00, 32'h12345678, 32'h12345000}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic fault(input logic [31:0] a, input logic w);
      @(negedge clk);
      fault_req_i   = 1'b1;
      fault_addr_i  = a;
      fault_write_i = w;
      @(negedge clk);
      fault_req_i   = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h04, d); chk("R1 status", d, 32'h80000018);
      rd(8'h00, d); chk("R1 dir", d, 32'h0);
      rd(8'h1C, d); chk("R1 mask", d, 32'h0);
      chk("R1 irq", {31'b0, irq_o}, 32'h0);

      // R2 R11 R12 register table
      for (int i = 0; i < 9; i++) begin
         wr(VEC[i][71:64], VEC[i][63:32]);
         rd(VEC[i][71:64], d);
         chk($sformatf("table R2 R11 R12 row %0d", i), d, VEC[i][31:0]);
      end
      chk("R12 gate output", {31'b0, clk_gate_en_o}, 32'h0);

      // R5 stall on dropped while paging is off
      wr(8'h08, 32'd2);
      repeat (D + 3) @(negedge clk);
      rd(8'h04, d); chk("R5 stall ignored when paging off", d & 32'h80000004, 32'h80000000);

      // R3 unknown command
      wr(8'h08, 32'd7);
      repeat (D + 2) @(negedge clk);
      rd(8'h04, d); chk("R3 code 7 no effect", d & 32'h80000007, 32'h80000000);

      // R3 paging on timing
      wr(8'h08, 32'd0);
      repeat (D - 1) @(negedge clk);
      rd(8'h04, d); chk("R3 paging before delay", d & 32'h1, 32'h0);
      @(negedge clk);
      rd(8'h04, d); chk("R3 paging after delay", d & 32'h1, 32'h1);

      // R5 stall waits for in-flight walk
      walk_busy_i = 1'b1;
      wr(8'h08, 32'd2);
      repeat (D + 4) @(negedge clk);
      chk("R5 stall held by busy walk", {31'b0, stall_on_o}, 32'h0);
      walk_busy_i = 1'b0;
      repeat (D - 1) @(negedge clk);
      chk("R5 stall one cycle early", {31'b0, stall_on_o}, 32'h0);
      @(negedge clk);
      rd(8'h04, d); chk("R5 stall granted", d & 32'h80000004, 32'h00000004);
      wr(8'h08, 32'd3);
      repeat (D) @(negedge clk);
      rd(8'h04, d); chk("R5 stall released", d & 32'h80000004, 32'h80000000);

      // R6 flush pulse
      wr(8'h08, 32'd4);
      chk("R6 flush pulse", {31'b0, flush_all_o}, 32'h1);
      @(negedge clk);
      chk("R6 flush one cycle", {31'b0, flush_all_o}, 32'h0);

      // R7 line invalidate
      wr(8'h10, 32'h12345ABC);
      chk("R7 line pulse", {31'b0, line_inv_o}, 32'h1);
      chk("R7 line page", {12'b0, line_page_o}, 32'h00012345);
      @(negedge clk);
      chk("R7 line one cycle", {31'b0, line_inv_o}, 32'h0);

      // R8 fault capture and hold
      fault(32'hDEAD1234, 1'b1);
      rd(8'h04, d); chk("R8 fault status", d & 32'h22, 32'h22);
      rd(8'h0C, d); chk("R8 fault addr", d, 32'hDEAD1234);
      rd(8'h14, d); chk("R8 raw fault bit", d, 32'h1);
      fault(32'h00001111, 1'b0);
      rd(8'h0C, d); chk("R8 second fault ignored", d, 32'hDEAD1234);
      rd(8'h04, d); chk("R8 direction held", d & 32'h20, 32'h20);

      // R11 masking
      chk("R11 irq masked off", {31'b0, irq_o}, 32'h0);
      wr(8'h1C, 32'h1);
      rd(8'h20, d); chk("R11 masked status", d, 32'h1);
      chk("R11 irq on", {31'b0, irq_o}, 32'h1);

      // R9 fault handled
      wr(8'h08, 32'd5);
      rd(8'h04, d); chk("R9 fault released", d & 32'h2, 32'h0);
      fault(32'h00002222, 1'b0);
      rd(8'h0C, d); chk("R9 next fault captured", d, 32'h00002222);

      // R10 bus error and clear
      @(negedge clk); bus_err_i = 1'b1;
      @(negedge clk); bus_err_i = 1'b0;
      rd(8'h14, d); chk("R10 bus error raw", d, 32'h3);
      wr(8'h18, 32'h3);
      rd(8'h14, d); chk("R10 clear", d, 32'h0);
      chk("R11 irq cleared", {31'b0, irq_o}, 32'h0);
      // R10 collision: clear and bus error at same edge
      @(negedge clk);
      reg_addr = 8'h18; reg_wdata = 32'h3; reg_wr = 1'b1; bus_err_i = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; bus_err_i = 1'b0;
      rd(8'h14, d); chk("R10 set wins over clear", d, 32'h2);

      // R4 force reset with held fault
      fault(32'h0000ABCD, 1'b1);
      wr(8'h00, 32'hCAFEBABE);
      wr(8'h08, 32'd6);
      repeat (D - 1) @(negedge clk);
      rd(8'h00, d); chk("R4 dir before delay", d, 32'hCAFEB000);
      @(negedge clk);
      rd(8'h00, d); chk("R4 dir cleared", d, 32'h0);
      rd(8'h04, d); chk("R4 paging and fault off", d & 32'h3, 32'h0);
      chk("R4 paging output", {31'b0, paging_on_o}, 32'h0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule